// File: doc/BRIEF.md
# Interleaved Multi-Bank Cell Buffer

This block is the storage stage of a shared-memory switch. Packets arrive already cut into cells of equal size. Each cell is streamed in one byte per cycle. The block packs the bytes of a cell into one word and writes the word into one of several slow memory banks. Banks are picked in a fixed rotation, so back-to-back cells always land on different banks. In this way a set of banks that are each too slow alone can together keep up with twice the line rate, which is one write and one read per cell slot.

Each bank has its own busy timer. After any accepted access, the timer keeps the bank closed for a programmable number of cycles. The output side reads a cell by naming a bank and a slot. The data comes back exactly one cycle later, together with a valid pulse. If either side aims at a bank that is still busy, the block raises a conflict pulse for that side and does not perform the operation. For every write, the block reports the bank and slot it chose, so that a scheduler can later fetch the cell.

Top module: `cell_bank_buffer`

## Requirements
- R1: After reset, all busy flags and all output pulses are low. The first accepted cell goes to bank 0, slot 0.
- R2: A cell is formed from CELL_BYTES bytes that are accepted only while `inValid` is high; the first byte becomes the most significant byte. Cycles with `inValid` low neither add a byte nor advance the cell. The write is attempted at the clock edge that takes the last byte, and `wrDone` or `wrConflict` is reported for one cycle after that edge.
- R3: Accepted cells go to banks 0, 1, …, NUM_BANKS-1 in turn. After the last bank the rotation returns to bank 0 and the slot number increases by one. The slot number wraps modulo SLOTS. `wrBank` and `wrSlot` report the location of each attempt.
- R4: Every accepted write or read sets the bank's bit in `bankBusy` for exactly BUSY_CYCLES cycles after its edge. A bank becomes busy only through an accepted access.
- R5: If a completed cell targets a busy bank, `wrConflict` pulses. The cell is dropped and nothing is written. The rotation does not advance, so the next cell retries the same bank and slot.
- R6: A read request to an idle bank returns the word stored at that bank and slot on `rdData`, with `rdValid` high, one cycle after the request.
- R7: A read request to a busy bank, or to a bank number of NUM_BANKS or above, pulses `rdConflict`. It produces no `rdValid` and does not restart the bank's busy time.
- R8: If a write and a read target the same idle bank in the same cycle, the write is performed and the read gets `rdConflict`.
- R9: A write and a read that target two different idle banks in the same cycle are both performed.
- R10: A continuous stream of cells at full byte rate with no reads never produces a write conflict when NUM_BANKS × CELL_BYTES exceeds BUSY_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is valid this cycle |
| inByte | input | 8 | Input cell byte, most significant first |
| rdReq | input | 1 | Read request |
| rdBank | input | BANK_W | Bank to read |
| rdSlot | input | SLOT_W | Slot to read within the bank |
| wrDone | output | 1 | Cell written last cycle |
| wrConflict | output | 1 | Cell dropped last cycle, target bank busy |
| wrBank | output | BANK_W | Bank of the last write attempt |
| wrSlot | output | SLOT_W | Slot of the last write attempt |
| rdValid | output | 1 | `rdData` holds requested word |
| rdData | output | CELL_BYTES*8 | Read word |
| rdConflict | output | 1 | Read refused last cycle |
| bankBusy | output | NUM_BANKS | Per-bank busy flag |

## Verification
The write at the end of a cell and a read request from the output side can arrive in the same cycle. Directed cases line up the last byte of a cell with a read of the same bank. Other directed cases line it up with a read of a different idle bank, so that both the write-first rule and the dual acceptance are checked. A read is also issued just ahead of a cell's completion, so that the write meets a busy bank and is dropped. Random traffic then mixes bytes and reads freely. Every outcome is judged against a bench model of the rotation, the per-bank timers and the stored words.

// File: rtl/cell_bank_buffer_pkg.sv
package cell_bank_buffer_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic shiftEn;  // take inByte into the gather register
    logic wrEn;     // write the completed word into the selected bank
    logic rdEn;     // capture the selected bank word onto rdData
  } strobe_t;

endpackage

// File: rtl/cell_bank_buffer_ctrl.sv
module cell_bank_buffer_ctrl
  import cell_bank_buffer_pkg::*;
#(
  parameter int NUM_BANKS   = 13,
  parameter int SLOTS       = 16,
  parameter int CELL_BYTES  = 4,
  parameter int BUSY_CYCLES = 6,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BYTE_W = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1,
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 rdReq,
  input  logic [BANK_W-1:0]    rdBank,
  output strobe_t              strobe,
  output logic [BANK_W-1:0]    wrBankSel,
  output logic [SLOT_W-1:0]    wrSlotSel,
  output logic                 wrDone,
  output logic                 wrConflict,
  output logic [BANK_W-1:0]    wrBank,
  output logic [SLOT_W-1:0]    wrSlot,
  output logic                 rdValid,
  output logic                 rdConflict,
  output logic [NUM_BANKS-1:0] bankBusy
);

  logic [BYTE_W-1:0] byteCnt;
  logic [BANK_W-1:0] ptr;
  logic [SLOT_W-1:0] slot;
  logic [NUM_BANKS-1:0] busyVec;

  logic cellLast;
  logic ptrBusy;
  logic rdInRange;
  logic rdTargetBusy;
  logic wrGo;
  logic rdGo;

  // Per-bank busy timers
  for (genvar i = 0; i < NUM_BANKS; i++) begin : gTimer
    logic [CNT_W-1:0] busyCnt;
    logic hit;
    assign hit = (wrGo && ptr == BANK_W'(i)) || (rdGo && rdBank == BANK_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        busyCnt <= '0;
      end else if (hit) begin
        busyCnt <= CNT_W'(BUSY_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
    assign busyVec[i] = (busyCnt != '0);
  end

  // Access decisions
  always_comb begin
    cellLast     = inValid && (byteCnt == BYTE_W'(CELL_BYTES - 1));
    ptrBusy      = busyVec[ptr];
    rdInRange    = (int'(rdBank) < NUM_BANKS);
    rdTargetBusy = rdInRange ? busyVec[rdBank] : 1'b1;
    wrGo         = cellLast && !ptrBusy;
    rdGo         = rdReq && !rdTargetBusy && !(wrGo && (rdBank == ptr));
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.wrEn    = wrGo;
    strobe.rdEn    = rdGo;
    wrBankSel      = ptr;
    wrSlotSel      = slot;
  end

  // Byte gather counter
  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
    end else if (inValid) begin
      byteCnt <= cellLast ? '0 : byteCnt + 1'b1;
    end
  end

  // Rotation pointer and slot
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      slot <= '0;
    end else if (wrGo) begin
      if (ptr == BANK_W'(NUM_BANKS - 1)) begin
        ptr  <= '0;
        slot <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // Registered report
  always_ff @(posedge clk) begin
    if (rst) begin
      wrDone     <= 1'b0;
      wrConflict <= 1'b0;
      wrBank     <= '0;
      wrSlot     <= '0;
      rdValid    <= 1'b0;
      rdConflict <= 1'b0;
    end else begin
      wrDone     <= wrGo;
      wrConflict <= cellLast && !wrGo;
      if (cellLast) begin
        wrBank <= ptr;
        wrSlot <= slot;
      end
      rdValid    <= rdGo;
      rdConflict <= rdReq && !rdGo;
    end
  end

  assign bankBusy = busyVec;

endmodule

// File: rtl/cell_bank_buffer_dp.sv
module cell_bank_buffer_dp
  import cell_bank_buffer_pkg::*;
#(
  parameter int NUM_BANKS  = 13,
  parameter int SLOTS      = 16,
  parameter int CELL_BYTES = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CELL_W = CELL_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [7:0]        inByte,
  input  logic [BANK_W-1:0] wrBankSel,
  input  logic [SLOT_W-1:0] wrSlotSel,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [CELL_W-1:0] rdData
);

  logic [CELL_W-1:0] shiftReg;
  logic [CELL_W-1:0] cellWord;
  logic [CELL_W-1:0] bankWord [NUM_BANKS];

  assign cellWord = {shiftReg[CELL_W-9:0], inByte};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= cellWord;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [CELL_W-1:0] store [SLOTS];
    always_ff @(posedge clk) begin
      if (strobe.wrEn && wrBankSel == BANK_W'(b)) begin
        store[wrSlotSel] <= cellWord;
      end
    end
    assign bankWord[b] = store[rdSlot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      rdData <= bankWord[rdBank];
    end
  end

endmodule

// File: rtl/cell_bank_buffer.sv
module cell_bank_buffer
  import cell_bank_buffer_pkg::*;
#(
  parameter int NUM_BANKS   = 13,
  parameter int SLOTS       = 16,
  parameter int CELL_BYTES  = 4,
  parameter int BUSY_CYCLES = 6,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CELL_W = CELL_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [7:0]           inByte,
  input  logic                 rdReq,
  input  logic [BANK_W-1:0]    rdBank,
  input  logic [SLOT_W-1:0]    rdSlot,
  output logic                 wrDone,
  output logic                 wrConflict,
  output logic [BANK_W-1:0]    wrBank,
  output logic [SLOT_W-1:0]    wrSlot,
  output logic                 rdValid,
  output logic [CELL_W-1:0]    rdData,
  output logic                 rdConflict,
  output logic [NUM_BANKS-1:0] bankBusy
);

  strobe_t           strobe;
  logic [BANK_W-1:0] wrBankSel;
  logic [SLOT_W-1:0] wrSlotSel;

  cell_bank_buffer_ctrl #(
    .NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS),
    .CELL_BYTES(CELL_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .rdReq(rdReq), .rdBank(rdBank),
    .strobe(strobe), .wrBankSel(wrBankSel), .wrSlotSel(wrSlotSel),
    .wrDone(wrDone), .wrConflict(wrConflict), .wrBank(wrBank), .wrSlot(wrSlot),
    .rdValid(rdValid), .rdConflict(rdConflict), .bankBusy(bankBusy)
  );

  cell_bank_buffer_dp #(
    .NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS), .CELL_BYTES(CELL_BYTES)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .inByte(inByte),
    .wrBankSel(wrBankSel), .wrSlotSel(wrSlotSel),
    .rdBank(rdBank), .rdSlot(rdSlot), .rdData(rdData)
  );

endmodule

// File: rtl/cell_bank_buffer_chk.sv
module cell_bank_buffer_chk #(
  parameter int NUM_BANKS = 13,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 rdReq,
  input logic                 wrDone,
  input logic                 wrConflict,
  input logic [BANK_W-1:0]    wrBank,
  input logic                 rdValid,
  input logic                 rdConflict,
  input logic [NUM_BANKS-1:0] bankBusy
);

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(wrDone && wrConflict)); // R5
  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rdValid && rdConflict)); // R7
  AST_WR_FROM_BYTE: assert property (@(posedge clk) disable iff (rst) (wrDone || wrConflict) |-> $past(inValid)); // R2
  AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (rst) (rdValid || rdConflict) |-> $past(rdReq)); // R6
  AST_WR_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) wrDone |-> bankBusy[wrBank]); // R4
  AST_BUSY_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ((bankBusy & ~$past(bankBusy)) != '0) |-> (wrDone || rdValid)); // R4
  AST_AT_MOST_TWO_RISE: assert property (@(posedge clk) disable iff (rst)
    $countones(bankBusy & ~$past(bankBusy)) <= 2); // R9

endmodule

bind cell_bank_buffer cell_bank_buffer_chk #(.NUM_BANKS(NUM_BANKS)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .rdReq(rdReq),
  .wrDone(wrDone), .wrConflict(wrConflict), .wrBank(wrBank),
  .rdValid(rdValid), .rdConflict(rdConflict), .bankBusy(bankBusy)
);

// File: tb/sim_cell_bank_buffer.sv
module sim_cell_bank_buffer;

  localparam int NB = 13;
  localparam int NS = 16;
  localparam int CB = 4;
  localparam int BUSY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic rdReq = 1'b0;
  logic [3:0] rdBank = '0;
  logic [3:0] rdSlot = '0;
  logic wrDone, wrConflict, rdValid, rdConflict;
  logic [3:0] wrBank, wrSlot;
  logic [31:0] rdData;
  logic [NB-1:0] bankBusy;

  always #5 clk = ~clk;

  cell_bank_buffer #(.NUM_BANKS(NB), .SLOTS(NS), .CELL_BYTES(CB), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte), .rdReq(rdReq),
    .rdBank(rdBank), .rdSlot(rdSlot), .wrDone(wrDone), .wrConflict(wrConflict),
    .wrBank(wrBank), .wrSlot(wrSlot), .rdValid(rdValid), .rdData(rdData),
    .rdConflict(rdConflict), .bankBusy(bankBusy)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // Reference model state
  int mBusy [NB];
  int mPtr, mSlot, mByteCnt;
  logic [31:0] mShift;
  logic [31:0] mMem [NB][NS];
  bit mWritten [NB][NS];
  int wrConfCount;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NB-1:0] busyExp();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (mBusy[i] != 0);
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NB; i++) begin
      mBusy[i] = 0;
      for (int j = 0; j < NS; j++) mWritten[i][j] = 0;
    end
    mPtr = 0; mSlot = 0; mByteCnt = 0; mShift = '0;
  endtask

  // One clock cycle: drive, predict, step, compare
  task automatic cyc(input bit v, input logic [7:0] b, input bit rq, input int rb, input int rs);
    bit cellLast, wGo, rGo, rIdle, sameBank;
    logic [31:0] word, expData;
    bit dataKnown;
    inValid = v; inByte = b; rdReq = rq; rdBank = 4'(rb); rdSlot = 4'(rs);
    cellLast = v && (mByteCnt == CB - 1);
    word = {mShift[23:0], b};
    wGo = cellLast && (mBusy[mPtr] == 0);
    rIdle = 0;
    if (rb < NB) rIdle = (mBusy[rb] == 0);
    sameBank = wGo && (rb == mPtr);
    rGo = rq && rIdle && !sameBank;
    expData = '0; dataKnown = 0;
    if (rGo && mWritten[rb][rs]) begin expData = mMem[rb][rs]; dataKnown = 1; end
    @(posedge clk);
    @(negedge clk);
    chk(wrDone === wGo, cellLast && !wGo ? "R5" : "R3", 64'(wrDone), 64'(wGo));
    chk(wrConflict === (cellLast && !wGo), "R5", 64'(wrConflict), 64'(cellLast && !wGo));
    if (cellLast) begin
      chk(wrBank === 4'(mPtr), "R3", 64'(wrBank), 64'(mPtr));
      chk(wrSlot === 4'(mSlot), "R3", 64'(wrSlot), 64'(mSlot));
    end
    chk(rdValid === rGo, sameBank && rq ? "R8" : "R6", 64'(rdValid), 64'(rGo));
    chk(rdConflict === (rq && !rGo), sameBank ? "R8" : "R7", 64'(rdConflict), 64'(rq && !rGo));
    if (dataKnown) chk(rdData === expData, "R6", 64'(rdData), 64'(expData));
    // model update
    for (int i = 0; i < NB; i++) if (mBusy[i] > 0) mBusy[i]--;
    if (wGo) begin
      mBusy[mPtr] = BUSY;
      mMem[mPtr][mSlot] = word;
      mWritten[mPtr][mSlot] = 1;
      if (mPtr == NB - 1) begin mPtr = 0; mSlot = (mSlot + 1) % NS; end
      else mPtr++;
    end
    if (cellLast && !wGo) wrConfCount++;
    if (rGo) mBusy[rb] = BUSY;
    if (v) begin
      mShift = word;
      mByteCnt = cellLast ? 0 : mByteCnt + 1;
    end
    chk(bankBusy === busyExp(), "R4", 64'(bankBusy), 64'(busyExp()));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 8'h00, 0, 0, 0);
  endtask

  task automatic sendCell(input logic [31:0] w);
    for (int k = 0; k < CB; k++) cyc(1, w[31-8*k -: 8], 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired, all requirements unchecked actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin : main
    int rnd;
    rnd = $urandom(32'd20240611);
    modelReset();
    wrConfCount = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bankBusy === '0, "R1", 64'(bankBusy), 64'd0);
    chk(!wrDone && !wrConflict, "R1", 64'({wrDone, wrConflict}), 64'd0);
    chk(!rdValid && !rdConflict, "R1", 64'({rdValid, rdConflict}), 64'd0);
    rst = 1'b0;

    // R2: gathering with idle gaps, first byte most significant
    cyc(1, 8'hA1, 0, 0, 0); idle(2);
    cyc(1, 8'hB2, 0, 0, 0); idle(1);
    cyc(1, 8'hC3, 0, 0, 0);
    cyc(1, 8'hD4, 0, 0, 0);
    chk(wrDone && wrBank == 0 && wrSlot == 0, "R1", 64'({wrBank, wrSlot}), 64'd0);
    idle(BUSY);
    cyc(0, 8'h00, 1, 0, 0);
    chk(rdValid && rdData == 32'hA1B2C3D4, "R2", 64'(rdData), 64'hA1B2C3D4);
    idle(BUSY);

    // R7: read right after a write to the same bank, busy time not extended
    sendCell(32'h11223344);                      // bank 1
    chk(bankBusy[1] === 1'b1, "R4", 64'(bankBusy[1]), 64'd1);
    cyc(0, 8'h00, 1, 1, 0);
    chk(rdConflict && !rdValid, "R7", 64'({rdConflict, rdValid}), 64'b10);
    idle(BUSY - 2);
    chk(bankBusy[1] === 1'b1, "R7", 64'(bankBusy[1]), 64'd1);
    idle(1);
    chk(bankBusy[1] === 1'b0, "R7", 64'(bankBusy[1]), 64'd0);

    // R8: cell completion and read of the same idle bank (bank 2)
    cyc(1, 8'h55, 0, 0, 0); cyc(1, 8'h66, 0, 0, 0); cyc(1, 8'h77, 0, 0, 0);
    cyc(1, 8'h88, 1, 2, 0);
    chk(wrDone && rdConflict && !rdValid, "R8", 64'({wrDone, rdConflict, rdValid}), 64'b110);

    // R9: cell to bank 3 with read of idle bank 0
    cyc(1, 8'h01, 0, 0, 0); cyc(1, 8'h02, 0, 0, 0); cyc(1, 8'h03, 0, 0, 0);
    cyc(1, 8'h04, 1, 0, 0);
    chk(wrDone && wrBank == 3 && rdValid && rdData == 32'hA1B2C3D4, "R9",
        64'({wrDone, rdValid, rdData}), 64'({2'b11, 32'hA1B2C3D4}));
    idle(BUSY);

    // R5: read makes bank 4 busy, the next cell is dropped and then retried
    cyc(0, 8'h00, 1, 4, 0);
    sendCell(32'hDEADBEEF);
    chk(wrConflict && !wrDone && wrBank == 4, "R5", 64'({wrConflict, wrDone, wrBank}), 64'({2'b10, 4'd4}));
    sendCell(32'hCAFEF00D);
    chk(wrDone && wrBank == 4 && wrSlot == 0, "R5", 64'({wrDone, wrBank, wrSlot}), 64'({1'b1, 4'd4, 4'd0}));
    idle(BUSY);
    cyc(0, 8'h00, 1, 4, 0);
    chk(rdData == 32'hCAFEF00D, "R5", 64'(rdData), 64'hCAFEF00D);
    idle(BUSY);

    // R10 and R3: long back-to-back stream, slot wraps
    wrConfCount = 0;
    for (int c = 0; c < 220; c++) sendCell($urandom);
    chk(wrConfCount == 0, "R10", 64'(wrConfCount), 64'd0);
    idle(BUSY);

    // Random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bit v, rq;
      v = ($urandom_range(0, 9) < 7);
      rq = ($urandom_range(0, 9) < 3);
      cyc(v, 8'($urandom), rq, $urandom_range(0, 15), $urandom_range(0, NS - 1));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule